// File: doc/BRIEF.md
# RGB to YCbCr 4:2:2 Front End

This block takes a stream of full-bandwidth 24-bit RGB pixels, 8 bits per component, and turns it into a 4:2:2 YCbCr stream. Each pixel first passes through a fixed-point colour space converter that produces 8-bit Y, Cb and Cr samples. Only the two chroma components then go through a horizontal 2:1 decimator, a [1,2,1]/4 low-pass filter. The decimator keeps one Cb and one Cr for every pair of pixels, co-sited with the even pixel of the pair. Luma skips the filter and instead runs through a matched delay line, so every output Y sample leaves in step with the chroma value that belongs to it.

The output carries one Y sample per input pixel. It comes with one chroma sample that alternates between Cb and Cr, and each line starts with Cb. The same data appears twice: as separate Y and C buses with a Cr-select flag, and as one interleaved 16-bit word. Valid and line-start markers travel through the same fixed pipeline as the data. The upstream source must hold valid high from the first pixel of a line to its last, and every line must contain an even number of pixels. Idle cycles may occur only between lines.

Top module: `rgb2ycc422`

## Requirements
- R1: For each valid pixel, o_y equals 16 + floor((66·R + 129·G + 25·B + 128) / 256), clamped to 16..235.
- R2: Unfiltered chroma per pixel is Cb = 128 + floor((−38·R − 74·G + 112·B + 128) / 256) and Cr = 128 + floor((112·R − 94·G − 18·B + 128) / 256), each clamped to 16..240. All output chroma lies in 16..240.
- R3: Pixels 2m and 2m+1 of a line form pair m. The pair's output chroma is (L + 2·E + O + 2) >> 2 for each of Cb and Cr, where E and O are the unfiltered values of pixels 2m and 2m+1, and L is the value of pixel 2m−1.
- R4: A valid pixel with i_sol = 1 is pixel 0 of a new line. For pair 0, L is pixel 0's own value, never the last pixel of the previous line, even when lines follow back to back.
- R5: The even pixel of a pair leaves with its pair's Cb and o_cr_sel = 0. The odd pixel leaves with its pair's Cr and o_cr_sel = 1. The first output of every line has o_cr_sel = 0, and within a line o_cr_sel toggles on every valid output.
- R6: Y, C, o_cr_sel, o_valid and o_sol appear exactly 4 clock cycles after the input pixel is presented. o_sol is high only on the output of a line's pixel 0.
- R7: o_yc carries the chroma sample in bits 15:8 and the Y sample in bits 7:0 of the same output pixel.
- R8: While rst is high, o_valid, o_sol, o_cr_sel, o_y and o_c read 0 one cycle later.
- R9: Cycles with i_valid = 0 produce o_valid = 0 four cycles later and leave the filter state untouched, whatever i_sol and the colour inputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Input pixel valid |
| i_sol | input | 1 | Input pixel is the first of a line |
| i_r | input | 8 | Red component |
| i_g | input | 8 | Green component |
| i_b | input | 8 | Blue component |
| o_valid | output | 1 | Output sample valid |
| o_sol | output | 1 | Output sample is the first of a line |
| o_cr_sel | output | 1 | 0: o_c is Cb, 1: o_c is Cr |
| o_y | output | 8 | Luma sample |
| o_c | output | 8 | Chroma sample (alternating Cb/Cr) |
| o_yc | output | 16 | Interleaved word {chroma, luma} |

## Verification
Two events can land on the same clock edge. In one, the odd pixel of pair m samples the held Cr while the decimator overwrites that register with pair m+1. In the other, a back-to-back line start resets the filter phase while the previous line's last chroma is still held as the left neighbour. The bench provokes both by streaming lines with zero, one or three idle cycles between them, and gives every pixel a distinct colour from a sweep over the RGB cube. It judges each output against the pair values it computes arithmetically from the requirement formulas. A stale Cr or a left neighbour carried over from the previous line shows up as a miscompare on that exact pixel.

// File: rtl/rgb2ycc_pkg.sv
package rgb2ycc_pkg;

    localparam int COMP_W   = 8;
    localparam int FRAC     = 8;
    localparam int RND      = 1 << (FRAC - 1);
    localparam int LATENCY  = 4;

    localparam int KYR = 66;
    localparam int KYG = 129;
    localparam int KYB = 25;
    localparam int KBR = -38;
    localparam int KBG = -74;
    localparam int KBB = 112;
    localparam int KRR = 112;
    localparam int KRG = -94;
    localparam int KRB = -18;

    localparam int Y_OFS = 16;
    localparam int C_OFS = 128;
    localparam int Y_MIN = 16;
    localparam int Y_MAX = 235;
    localparam int C_MIN = 16;
    localparam int C_MAX = 240;

    typedef logic [COMP_W-1:0] comp_t;

    typedef struct packed {
        comp_t r;
        comp_t g;
        comp_t b;
    } rgb_t;

    typedef struct packed {
        comp_t y;
        comp_t cb;
        comp_t cr;
    } ycc_t;

    typedef struct packed {
        logic  vld;
        logic  sol;
        logic  odd;
        comp_t y;
    } luma_tag_t;

    function automatic comp_t clamp_comp(input int v, input int lo, input int hi);
        int t;
        t = (v < lo) ? lo : ((v > hi) ? hi : v);
        return comp_t'(t);
    endfunction

    function automatic comp_t mac3(input int kr, input int kg, input int kb,
                                   input rgb_t p, input int ofs,
                                   input int lo, input int hi);
        int acc;
        acc = kr * int'(p.r) + kg * int'(p.g) + kb * int'(p.b) + RND;
        acc = acc >>> FRAC;
        return clamp_comp(acc + ofs, lo, hi);
    endfunction

    function automatic ycc_t rgb_to_ycc(input rgb_t p);
        ycc_t o;
        o.y  = mac3(KYR, KYG, KYB, p, Y_OFS, Y_MIN, Y_MAX);
        o.cb = mac3(KBR, KBG, KBB, p, C_OFS, C_MIN, C_MAX);
        o.cr = mac3(KRR, KRG, KRB, p, C_OFS, C_MIN, C_MAX);
        return o;
    endfunction

endpackage

// File: rtl/ycc_csc.sv
module ycc_csc
    import rgb2ycc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_vld,
    input  logic in_sol,
    input  rgb_t in_px,
    output logic out_vld,
    output logic out_sol,
    output ycc_t out_px
);

    ycc_t conv;

    always_comb conv = rgb_to_ycc(in_px);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_sol <= 1'b0;
            out_px  <= '0;
        end else begin
            out_vld <= in_vld;
            out_sol <= in_vld & in_sol;
            out_px  <= conv;
        end
    end

endmodule

// File: rtl/ycc_tap121.sv
module ycc_tap121
    import rgb2ycc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  vld,
    input  logic  sol,
    input  logic  odd,
    input  comp_t c_in,
    output comp_t c_avg
);

    localparam int SUM_W = COMP_W + 2;

    comp_t            last_q;
    comp_t            left_q;
    comp_t            even_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = {2'b00, left_q} + {1'b0, even_q, 1'b0} + {2'b00, c_in} + SUM_W'(2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '0;
            left_q <= '0;
            even_q <= '0;
            c_avg  <= '0;
        end else if (vld) begin
            last_q <= c_in;
            if (!odd) begin
                even_q <= c_in;
                left_q <= sol ? c_in : last_q;
            end else begin
                c_avg <= sum[SUM_W-1:2];
            end
        end
    end

endmodule

// File: rtl/ycc_chroma_dec.sv
module ycc_chroma_dec
    import rgb2ycc_pkg::*;
#(
    parameter int NCOMP = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  vld,
    input  logic  sol,
    input  comp_t c_in  [NCOMP],
    output logic  odd,
    output comp_t c_out [NCOMP]
);

    logic last_odd_q;

    always_comb odd = sol ? 1'b0 : ~last_odd_q;

    always_ff @(posedge clk) begin
        if (rst) last_odd_q <= 1'b1;
        else if (vld) last_odd_q <= odd;
    end

    for (genvar k = 0; k < NCOMP; k++) begin : g_comp
        ycc_tap121 u_tap (
            .clk   (clk),
            .rst   (rst),
            .vld   (vld),
            .sol   (sol),
            .odd   (odd),
            .c_in  (c_in[k]),
            .c_avg (c_out[k])
        );
    end

    // R4: a line start always opens a new pair on its even sample
    p_sol_even_r4: assert property (@(posedge clk) disable iff (rst)
        (vld && sol) |=> (last_odd_q == 1'b0));

endmodule

// File: rtl/ycc_luma_delay.sv
module ycc_luma_delay
    import rgb2ycc_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  luma_tag_t tag_in,
    output luma_tag_t tag_out
);

    luma_tag_t stage_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) stage_q[i] <= '0;
                else     stage_q[i] <= tag_in;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) stage_q[i] <= '0;
                else     stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign tag_out = stage_q[DEPTH-1];

endmodule

// File: rtl/rgb2ycc422.sv
module rgb2ycc422
    import rgb2ycc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        i_valid,
    input  logic        i_sol,
    input  logic [7:0]  i_r,
    input  logic [7:0]  i_g,
    input  logic [7:0]  i_b,
    output logic        o_valid,
    output logic        o_sol,
    output logic        o_cr_sel,
    output logic [7:0]  o_y,
    output logic [7:0]  o_c,
    output logic [15:0] o_yc
);

    localparam int NCOMP   = 2;
    localparam int IDX_CB  = 0;
    localparam int IDX_CR  = 1;
    localparam int LDEPTH  = LATENCY - 2;
    localparam int AGE_W   = $clog2(LATENCY + 1);

    rgb_t      px_in;
    logic      s1_vld;
    logic      s1_sol;
    ycc_t      s1_px;
    logic      s1_odd;
    comp_t     c_in  [NCOMP];
    comp_t     c_dec [NCOMP];
    luma_tag_t tag_s1;
    luma_tag_t tag_out;

    assign px_in = '{r: i_r, g: i_g, b: i_b};

    ycc_csc u_csc (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (i_valid),
        .in_sol  (i_sol),
        .in_px   (px_in),
        .out_vld (s1_vld),
        .out_sol (s1_sol),
        .out_px  (s1_px)
    );

    assign c_in[IDX_CB] = s1_px.cb;
    assign c_in[IDX_CR] = s1_px.cr;

    ycc_chroma_dec #(.NCOMP(NCOMP)) u_dec (
        .clk   (clk),
        .rst   (rst),
        .vld   (s1_vld),
        .sol   (s1_sol),
        .c_in  (c_in),
        .odd   (s1_odd),
        .c_out (c_dec)
    );

    assign tag_s1 = '{vld: s1_vld, sol: s1_sol, odd: s1_odd, y: s1_px.y};

    ycc_luma_delay #(.DEPTH(LDEPTH)) u_ldly (
        .clk     (clk),
        .rst     (rst),
        .tag_in  (tag_s1),
        .tag_out (tag_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid  <= 1'b0;
            o_sol    <= 1'b0;
            o_cr_sel <= 1'b0;
            o_y      <= '0;
            o_c      <= '0;
        end else begin
            o_valid  <= tag_out.vld;
            o_sol    <= tag_out.vld & tag_out.sol;
            o_cr_sel <= tag_out.vld & tag_out.odd;
            o_y      <= tag_out.y;
            o_c      <= tag_out.odd ? c_dec[IDX_CR] : c_dec[IDX_CB];
        end
    end

    assign o_yc = {o_c, o_y};

    logic [AGE_W-1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst) age_q <= '0;
        else if (age_q != AGE_W'(LATENCY)) age_q <= age_q + 1'b1;
    end

    p_y_range_r1: assert property (@(posedge clk) disable iff (rst)
        o_valid |-> (o_y >= 8'(Y_MIN) && o_y <= 8'(Y_MAX)));

    p_c_range_r2: assert property (@(posedge clk) disable iff (rst)
        o_valid |-> (o_c >= 8'(C_MIN) && o_c <= 8'(C_MAX)));

    p_sol_cb_r5: assert property (@(posedge clk) disable iff (rst)
        (o_valid && o_sol) |-> !o_cr_sel);

    p_alternate_r5: assert property (@(posedge clk) disable iff (rst)
        (o_valid && $past(o_valid) && !o_sol) |-> (o_cr_sel != $past(o_cr_sel)));

    p_valid_latency_r6: assert property (@(posedge clk) disable iff (rst)
        (age_q == AGE_W'(LATENCY)) |-> (o_valid == $past(i_valid, 4)));

endmodule

// File: tb/rgb2ycc422_bench.sv
module rgb2ycc422_bench;

    localparam int NSLOT = 16384;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        i_valid = 1'b0;
    logic        i_sol = 1'b0;
    logic [7:0]  i_r = '0, i_g = '0, i_b = '0;
    logic        o_valid, o_sol, o_cr_sel;
    logic [7:0]  o_y, o_c;
    logic [15:0] o_yc;

    rgb2ycc422 u_rgb2ycc422 (
        .clk(clk), .rst(rst), .i_valid(i_valid), .i_sol(i_sol),
        .i_r(i_r), .i_g(i_g), .i_b(i_b),
        .o_valid(o_valid), .o_sol(o_sol), .o_cr_sel(o_cr_sel),
        .o_y(o_y), .o_c(o_c), .o_yc(o_yc)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    bit       ex_v   [NSLOT];
    bit       ex_s   [NSLOT];
    bit       ex_sel [NSLOT];
    int       ex_y   [NSLOT];
    int       ex_c   [NSLOT];
    bit       chk_on = 1'b0;
    logic [23:0] line_buf [16];

    function automatic int clampi(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction
    function automatic int ref_y(input int r, input int g, input int b);
        return clampi(16 + ((66*r + 129*g + 25*b + 128) >>> 8), 16, 235);
    endfunction
    function automatic int ref_cb(input int r, input int g, input int b);
        return clampi(128 + ((-38*r - 74*g + 112*b + 128) >>> 8), 16, 240);
    endfunction
    function automatic int ref_cr(input int r, input int g, input int b);
        return clampi(128 + ((112*r - 94*g - 18*b + 128) >>> 8), 16, 240);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic check_now();
        int k;
        k = cyc;
        if (!chk_on || k >= NSLOT) return;
        // R6 / R9: valid timing, idle cycles give no output
        chk(o_valid == ex_v[k], "R6/R9 valid", int'(o_valid), int'(ex_v[k]));
        if (ex_v[k]) begin
            chk(o_y == 8'(ex_y[k]), "R1 luma", int'(o_y), ex_y[k]);
            chk(o_c == 8'(ex_c[k]), "R3 chroma", int'(o_c), ex_c[k]);
            chk(o_cr_sel == ex_sel[k], "R5 cr_sel", int'(o_cr_sel), int'(ex_sel[k]));
            chk(o_sol == ex_s[k], "R6 sol", int'(o_sol), int'(ex_s[k]));
            chk(o_yc == {8'(ex_c[k]), 8'(ex_y[k])}, "R7 packing", int'(o_yc),
                (ex_c[k] << 8) | ex_y[k]);
        end
    endtask

    task automatic tick(input bit v, input bit s, input logic [23:0] rgb, output int slot);
        @(negedge clk);
        check_now();
        i_valid = v;
        i_sol   = s;
        {i_r, i_g, i_b} = rgb;
        slot = cyc + 4;
    endtask

    task automatic idle(input int n);
        int slot;
        for (int j = 0; j < n; j++)
            tick(1'b0, j[0], 24'hA5C3 ^ 24'(j * 7919), slot);  // R9: junk ignored
    endtask

    task automatic send_line(input int n);
        int slot, eslot, r, g, b, cb, cr, pcb, pcr, lcb, lcr, ecb, ecr;
        pcb = 0; pcr = 0; lcb = 0; lcr = 0; ecb = 0; ecr = 0; eslot = 0;
        for (int p = 0; p < n; p++) begin
            r = int'(line_buf[p][23:16]);
            g = int'(line_buf[p][15:8]);
            b = int'(line_buf[p][7:0]);
            cb = ref_cb(r, g, b);
            cr = ref_cr(r, g, b);
            tick(1'b1, p == 0, line_buf[p], slot);
            if (slot < NSLOT) begin
                ex_v[slot] = 1'b1;
                ex_s[slot] = (p == 0);
                ex_y[slot] = ref_y(r, g, b);
            end
            if (p % 2 == 0) begin
                lcb = (p == 0) ? cb : pcb;   // R4: left edge replicated
                lcr = (p == 0) ? cr : pcr;
                ecb = cb; ecr = cr; eslot = slot;
            end else if (slot < NSLOT) begin
                ex_c[eslot]   = (lcb + 2*ecb + cb + 2) >> 2;   // R3
                ex_sel[eslot] = 1'b0;                          // R5
                ex_c[slot]    = (lcr + 2*ecr + cr + 2) >> 2;
                ex_sel[slot]  = 1'b1;
            end
            pcb = cb; pcr = cr;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NSLOT; k++) begin
            ex_v[k] = 0; ex_s[k] = 0; ex_sel[k] = 0; ex_y[k] = 0; ex_c[k] = 0;
        end
        i_valid = 1'b1; i_sol = 1'b1; {i_r, i_g, i_b} = 24'hFFFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset values
        chk(o_valid == 1'b0 && o_sol == 1'b0 && o_cr_sel == 1'b0,
            "R8 flags", int'({o_valid, o_sol, o_cr_sel}), 0);
        chk(o_y == 8'd0 && o_c == 8'd0, "R8 data", int'(o_yc), 0);
        i_valid = 1'b0; i_sol = 1'b0;
        rst = 1'b0;
        chk_on = 1'b1;
        idle(3);

        // extremes of the cube, two-pixel lines back to back (R4)
        line_buf[0] = 24'h000000; line_buf[1] = 24'hFFFFFF; send_line(2);
        line_buf[0] = 24'hFF0000; line_buf[1] = 24'h00FF00; send_line(2);
        line_buf[0] = 24'h0000FF; line_buf[1] = 24'hFFFF00; send_line(2);
        line_buf[0] = 24'h00FFFF; line_buf[1] = 24'hFF00FF; send_line(2);
        idle(2);

        // sweep the RGB cube on a 16-step grid, 16-pixel lines, varied gaps
        for (int ln = 0; ln < 256; ln++) begin
            for (int p = 0; p < 16; p++) begin
                int idx;
                idx = ln * 16 + p;
                line_buf[p] = {8'((idx % 16) * 17), 8'(((idx / 16) % 16) * 17),
                               8'((idx / 256) * 17)};
            end
            send_line(16);
            if (ln % 3 == 1) idle(1);
            else if (ln % 3 == 2) idle(3);
        end

        idle(8);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule